// File: doc/BRIEF.md
# Descriptor RAM Zero-Fill Sequencer with Enable Interlock

This block clears a parity-protected descriptor RAM after power-up. A system controller raises a request. If the module is disabled and parity protection is on, the sequencer takes over the RAM write port. It writes an all-zero word to every address in turn, one per clock. Each word goes out with one parity bit per byte, and those bits follow the even/odd setting that is live at the time. When the last word is written, the sequencer raises a completion pulse and hands the write port back to the bus.

The block also holds the module-enable bit. A request that arrives while that bit is set is refused, so normal operation is never disturbed. A write of 1 to the bit during the clearing sequence is stored at once. The effective enable seen by the rest of the module stays low until the sequence is over. Bus writes to the RAM made while the block is idle pass straight through, with their parity computed here. Bus writes made during the sequence are dropped and flagged as stalled.

Top module: `ram_zero_init_seq`

## Requirements
- R1: After reset, init_busy, init_done, en_bit, en_eff and ram_we are all 0.
- R2: A request is accepted when init_request is 1, parity_en is 1, the stored en_bit is 0 and the block is idle. From the next cycle, init_busy is 1 and the block writes one word per cycle to addresses 0, 1, ..., DEPTH-1, with ram_wdata all zero.
- R3: During the sequence, every bit of ram_wpar equals parity_odd: 0 under even parity and 1 under odd parity, since every byte written is zero.
- R4: In the cycle after the write to address DEPTH-1, init_busy is 0 and init_done is 1. init_done is 1 for exactly one cycle.
- R5: A request made while en_bit is 1 is ignored. init_busy stays 0, ram_we stays 0 and en_eff stays 1.
- R6: A request made while parity_en is 0 is ignored. init_busy stays 0 and ram_we stays 0.
- R7: An enable write (en_wr=1, en_wdata=1) during the sequence sets en_bit on the next cycle. en_eff stays 0 while init_busy is 1 and becomes 1 in the cycle init_busy falls.
- R8: A bus RAM write during the sequence is dropped. bus_ram_stall is 1 in that cycle, and ram_addr and ram_wdata keep the sequencer's address and zero data.
- R9: While idle, a bus RAM write passes through in the same cycle with the same address and data. ram_wpar[i] covers byte i, which is ram_wdata[8i+7:8i]. The bit is 1 when that byte has an odd number of ones under even parity (parity_odd=0), and the inverse of that under odd parity.
- R10: A request during the sequence neither restarts nor extends it. The sequence still ends DEPTH cycles after it began.
- R11: While idle, en_eff equals en_bit. An enable write updates en_bit on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Clear request from the system controller |
| parity_en | input | 1 | Parity protection enabled |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| en_wr | input | 1 | Bus write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| bus_ram_we | input | 1 | Bus write strobe for the descriptor RAM |
| bus_ram_addr | input | ADDR_W | Bus RAM word address |
| bus_ram_wdata | input | DATA_W | Bus RAM write data |
| bus_ram_stall | output | 1 | Bus RAM write dropped because the sequence is running |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_wpar | output | DATA_W/8 | Parity bits, one per byte |
| init_busy | output | 1 | Sequence running |
| init_done | output | 1 | One-cycle completion pulse |
| en_bit | output | 1 | Stored module-enable bit |
| en_eff | output | 1 | Effective module enable |

## Verification
The bench clears the RAM under both parity settings. A design that wrote the wrong parity would show all-zero parity bits under odd parity. It writes the enable bit partway through a sequence. A design without the hold-off would raise the effective enable early. It also raises a second request during a sequence, which catches a design that restarts the counter and runs past DEPTH cycles. Requests made while the module is enabled or parity is off must leave the write port silent. A bus write aimed at the RAM mid-sequence must not replace the zero word or its address.

// File: rtl/rzi_pkg.sv
`timescale 1ns/1ps
package rzi_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Parity of one byte: reduction XOR, inverted for odd parity.
  function automatic logic byte_parity(input logic [BYTE_W-1:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

endpackage

// File: rtl/rzi_par_gen.sv
`timescale 1ns/1ps
module rzi_par_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 data,
  input  logic                              odd,
  output logic [DATA_W/rzi_pkg::BYTE_W-1:0] par
);
  localparam int NBYTES = DATA_W / rzi_pkg::BYTE_W;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign par[i] = rzi_pkg::byte_parity(data[i*rzi_pkg::BYTE_W +: rzi_pkg::BYTE_W], odd);
  end

  always_comb begin
    a_r9_par_width: assert (NBYTES * rzi_pkg::BYTE_W == DATA_W);
  end
endmodule

// File: rtl/rzi_walker.sv
`timescale 1ns/1ps
module rzi_walker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              done
);
  import rzi_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              done_q;

  assign busy = (state_q == SEQ_RUN);
  assign addr = cnt_q;
  assign last = busy && (cnt_q == LAST_ADDR);
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (last) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + ADDR_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && addr == '0));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && addr == $past(addr) + ADDR_W'(1)));
  a_r4_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rzi_en_gate.sv
`timescale 1ns/1ps
module rzi_en_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic hold,
  output logic en_bit,
  output logic en_eff
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign en_bit = en_q;
  assign en_eff = en_q && !hold;

  a_r7_bit_stored: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_bit == $past(en_wdata)));
  a_r11_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_bit));
endmodule

// File: rtl/ram_zero_init_seq.sv
`timescale 1ns/1ps
module ram_zero_init_seq #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int NBYTES = DATA_W / rzi_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              bus_ram_we,
  input  logic [ADDR_W-1:0] bus_ram_addr,
  input  logic [DATA_W-1:0] bus_ram_wdata,
  output logic              bus_ram_stall,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [NBYTES-1:0] ram_wpar,
  output logic              init_busy,
  output logic              init_done,
  output logic              en_bit,
  output logic              en_eff
);
  // Named internal events
  logic              seq_busy;
  logic              seq_last;
  logic              seq_done;
  logic [ADDR_W-1:0] seq_addr;
  logic              req_accept;
  logic              req_refused_en;
  logic              req_refused_par;
  logic              en_bit_w;

  assign req_accept      = init_req && parity_en && !en_bit_w && !seq_busy;
  assign req_refused_en  = init_req && en_bit_w && !seq_busy;
  assign req_refused_par = init_req && !parity_en && !seq_busy;

  rzi_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (req_accept),
    .busy  (seq_busy),
    .addr  (seq_addr),
    .last  (seq_last),
    .done  (seq_done)
  );

  rzi_en_gate u_en_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .hold     (seq_busy),
    .en_bit   (en_bit_w),
    .en_eff   (en_eff)
  );

  // Priority mux: the sequencer owns the port while busy.
  always_comb begin
    if (seq_busy) begin
      ram_we    = 1'b1;
      ram_addr  = seq_addr;
      ram_wdata = '0;
    end else begin
      ram_we    = bus_ram_we;
      ram_addr  = bus_ram_addr;
      ram_wdata = bus_ram_wdata;
    end
  end

  rzi_par_gen #(.DATA_W(DATA_W)) u_par_gen (
    .data (ram_wdata),
    .odd  (parity_odd),
    .par  (ram_wpar)
  );

  assign bus_ram_stall = seq_busy && bus_ram_we;
  assign init_busy     = seq_busy;
  assign init_done     = seq_done;
  assign en_bit        = en_bit_w;

  a_r2_zero_words: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (ram_we && ram_wdata == '0));
  a_r3_par_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (ram_wpar == {NBYTES{parity_odd}}));
  a_r5_refused_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused_en |=> !init_busy);
  a_r6_refused_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused_par |=> !init_busy);
  a_r7_eff_held: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !en_eff);
  a_r8_bus_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && bus_ram_we) |-> (bus_ram_stall && ram_addr == seq_addr));
endmodule

// File: tb/ram_zero_init_seq_tb.sv
`timescale 1ns/1ps
module ram_zero_init_seq_tb;
  localparam int DEPTH = 16;
  localparam int DATA_W = 32;
  localparam int NB = DATA_W / 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, parity_en = 1'b1, parity_odd = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic bus_ram_we = 1'b0;
  logic [AW-1:0] bus_ram_addr = '0;
  logic [DATA_W-1:0] bus_ram_wdata = '0;
  logic bus_ram_stall, ram_we, init_busy, init_done, en_bit, en_eff;
  logic [AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [NB-1:0] ram_wpar;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ram_zero_init_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .parity_en(parity_en),
    .parity_odd(parity_odd), .en_wr(en_wr), .en_wdata(en_wdata),
    .bus_ram_we(bus_ram_we), .bus_ram_addr(bus_ram_addr), .bus_ram_wdata(bus_ram_wdata),
    .bus_ram_stall(bus_ram_stall), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_wpar(ram_wpar), .init_busy(init_busy),
    .init_done(init_done), .en_bit(en_bit), .en_eff(en_eff)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected parity: count the ones in each byte; odd count -> 1 under even parity.
  function automatic logic [NB-1:0] exp_par(input logic [DATA_W-1:0] d, input logic odd);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      p[i] = (($countones(d[i*8 +: 8]) % 2) == 1) ? ~odd : odd;
    end
    return p;
  endfunction

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1", "busy", init_busy, 0);
    chk("R1", "done", init_done, 0);
    chk("R1", "en_bit", en_bit, 0);
    chk("R1", "en_eff", en_eff, 0);
    chk("R1", "ram_we", ram_we, 0);
  endtask

  task automatic t_init_run(input logic odd, input bit en_mid, input bit bus_mid, input bit req_mid);
    int bad_addr, bad_data, bad_par;
    bad_addr = 0; bad_data = 0; bad_par = 0;
    @(negedge clk);
    parity_odd = odd;
    init_req = 1'b1;
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++) begin
      init_req = 1'b0; en_wr = 1'b0; bus_ram_we = 1'b0;
      #1;
      if (!(init_busy && ram_we)) bad_addr++;
      if (ram_addr !== AW'(k)) bad_addr++;
      if (ram_wdata !== '0) bad_data++;
      if (ram_wpar !== exp_par('0, odd)) bad_par++;
      if (en_mid && k == 2) begin
        en_wr = 1'b1; en_wdata = 1'b1;
      end
      if (en_mid && k == 3) begin
        chk("R7", "en_bit set mid-sequence", en_bit, 1);
        chk("R7", "en_eff held low", en_eff, 0);
      end
      if (bus_mid && k == 5) begin
        bus_ram_we = 1'b1; bus_ram_addr = AW'(3); bus_ram_wdata = '1;
        #1;
        chk("R8", "stall", bus_ram_stall, 1);
        chk("R8", "addr kept", ram_addr, AW'(5));
        chk("R8", "data kept", ram_wdata, 0);
      end
      if (req_mid && k == 7) init_req = 1'b1;
      @(negedge clk);
    end
    init_req = 1'b0; en_wr = 1'b0; bus_ram_we = 1'b0;
    #1;
    chk("R2", "address walk errors", bad_addr, 0);
    chk("R2", "zero data errors", bad_data, 0);
    chk("R3", odd ? "odd parity errors" : "even parity errors", bad_par, 0);
    chk(req_mid ? "R10" : "R4", "busy cleared", init_busy, 0);
    chk("R4", "done pulse", init_done, 1);
    chk("R4", "ram_we idle", ram_we, 0);
    if (en_mid) chk("R7", "en_eff after sequence", en_eff, 1);
    @(negedge clk); #1;
    chk("R4", "done one cycle", init_done, 0);
  endtask

  task automatic t_refused_enabled();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0; #1;
    chk("R5", "busy", init_busy, 0);
    chk("R5", "ram_we", ram_we, 0);
    chk("R5", "en_eff", en_eff, 1);
  endtask

  task automatic t_enable_write(input logic v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0; #1;
    chk("R11", "en_bit", en_bit, v);
    chk("R11", "en_eff", en_eff, v);
  endtask

  task automatic t_parity_off();
    @(negedge clk); parity_en = 1'b0; init_req = 1'b1;
    @(negedge clk); init_req = 1'b0; #1;
    chk("R6", "busy", init_busy, 0);
    chk("R6", "ram_we", ram_we, 0);
    @(negedge clk); #1;
    chk("R6", "still idle", init_busy, 0);
    parity_en = 1'b1;
  endtask

  task automatic t_bus_idle(input logic [AW-1:0] a, input logic [DATA_W-1:0] d, input logic odd);
    @(negedge clk);
    parity_odd = odd; bus_ram_we = 1'b1; bus_ram_addr = a; bus_ram_wdata = d;
    #1;
    chk("R9", "we", ram_we, 1);
    chk("R9", "addr", ram_addr, a);
    chk("R9", "data", ram_wdata, d);
    chk("R9", "parity", ram_wpar, exp_par(d, odd));
    chk("R9", "no stall", bus_ram_stall, 0);
    @(negedge clk); bus_ram_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_init_run(1'b0, 0, 0, 0);
    t_init_run(1'b1, 1, 1, 0);
    t_refused_enabled();
    t_enable_write(1'b0);
    t_init_run(1'b1, 0, 0, 1);
    t_parity_off();
    t_bus_idle(AW'(5), 32'h0001_0380, 1'b0);
    t_bus_idle(AW'(DEPTH-1), 32'hA5FF_0701, 1'b1);
    t_bus_idle(AW'(0), 32'h0000_0000, 1'b1);
    t_enable_write(1'b1);
    t_enable_write(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule